// File: doc/BRIEF.md
# Event Status Register with Interrupt Request

This block keeps an 8-bit status byte for a voice record/playback controller. The byte holds three event flags and a 5-bit power reading. A power-measurement engine, a store engine and a play engine each raise a one-cycle event pulse. Each pulse sets its own flag and arms an interrupt request line. A global enable gates that line.

A host talks to the block through a byte-wide command port. The command code 0x61 asks for the status. The block answers with a reply byte, which is a snapshot taken in the same cycle as the command, so the host can inspect it at leisure. The command code 0x01 is a general reset of the status. Two more strobes report when a new store command or a new play command has been loaded. Each flag is cleared by its own event: a status read clears the power-ready flag, and loading the next command of the matching kind clears a completion flag.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset, status_o, rd_data_o and irq_o are all zero.
- R2: The status byte layout is: bit 7 = power reading ready, bit 6 = store complete, bit 5 = play complete, bits 4..0 = the power value. The power value is the pwr_val sampled with the most recent ev_pwr pulse.
- R3: An event pulse sets its flag in status_o on the next cycle. It also arms the interrupt, so irq_o is high from the next cycle while irq_en is high.
- R4: When irq_en is low, irq_o is low and the flags are unchanged. Raising irq_en again makes a still-pending interrupt visible on irq_o.
- R5: A cmd_wr with code 0x61 is a status read. On the next cycle, rd_data_o holds status_o as it was before that edge. The read also clears the power-ready flag and the pending interrupt.
- R6: A status read does not clear the store-complete flag. A store_load pulse clears it.
- R7: A status read does not clear the play-complete flag. A play_load pulse clears it.
- R8: A cmd_wr with code 0x01 clears all three flags, the power field and the pending interrupt.
- R9: An event that arrives in the same cycle as a clear of its flag wins. The flag stays set and the interrupt is re-armed. The event that arrives during a read is missing from that read's reply byte but is still present in status_o afterwards.
- R10: A cmd_wr with any other code changes neither status_o, rd_data_o nor irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pwr | input | 1 | Power reading ready pulse |
| ev_store | input | 1 | Store command complete pulse |
| ev_play | input | 1 | Play command complete pulse |
| pwr_val | input | 5 | Power reading sampled with ev_pwr |
| irq_en | input | 1 | Interrupt enable |
| store_load | input | 1 | A new store command was loaded |
| play_load | input | 1 | A new play command was loaded |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| status_o | output | 8 | Live status byte |
| rd_data_o | output | 8 | Reply byte captured by the last status read |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions treat every event pulse, load strobe and command strobe as a single-cycle request sampled at the clock edge. They place no limit on how these inputs overlap. Because events may collide with reads and loads, the properties that check a clear carry a condition that no competing event arrives in that cycle. The directed stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It creates collisions only in the scenario that is dedicated to them.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int unsigned CMD_W      = 8;
    localparam int unsigned PWR_W      = 5;
    localparam logic [CMD_W-1:0] CODE_STATUS_RD = 8'h61;
    localparam logic [CMD_W-1:0] CODE_GEN_RESET = 8'h01;

    typedef struct packed {
        logic pwr_rdy;
        logic store_done;
        logic play_done;
    } flags_t;
endpackage

// File: rtl/stat_cmd_dec.sv
module stat_cmd_dec
    import stat_pkg::*;
#(
    parameter int unsigned             W       = CMD_W,
    parameter logic [W-1:0]            RD_CODE = CODE_STATUS_RD,
    parameter logic [W-1:0]            GR_CODE = CODE_GEN_RESET
) (
    input  logic         cmd_wr,
    input  logic [W-1:0] cmd_code,
    output logic         rd_stb,
    output logic         grst_stb
);
    always_comb begin
        rd_stb   = cmd_wr && (cmd_code == RD_CODE);
        grst_stb = cmd_wr && (cmd_code == GR_CODE);
    end
endmodule

// File: rtl/stat_flag_bank.sv
module stat_flag_bank
    import stat_pkg::*;
#(
    parameter int unsigned PW = PWR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_pwr,
    input  logic          ev_store,
    input  logic          ev_play,
    input  logic [PW-1:0] pwr_val,
    input  logic          rd_stb,
    input  logic          grst_stb,
    input  logic          store_load,
    input  logic          play_load,
    output flags_t        flags_o,
    output logic [PW-1:0] power_o,
    output logic          pend_o
);
    typedef struct packed {
        flags_t        flags;
        logic [PW-1:0] power;
        logic          pend;
    } bank_t;

    bank_t st_d, st_q;
    logic  any_ev;

    always_comb begin
        st_d   = st_q;
        any_ev = ev_pwr || ev_store || ev_play;

        if (ev_pwr)                      st_d.flags.pwr_rdy = 1'b1;
        else if (rd_stb || grst_stb)     st_d.flags.pwr_rdy = 1'b0;

        if (ev_store)                    st_d.flags.store_done = 1'b1;
        else if (store_load || grst_stb) st_d.flags.store_done = 1'b0;

        if (ev_play)                     st_d.flags.play_done = 1'b1;
        else if (play_load || grst_stb)  st_d.flags.play_done = 1'b0;

        if (ev_pwr)                      st_d.power = pwr_val;
        else if (grst_stb)               st_d.power = '0;

        if (any_ev)                      st_d.pend = 1'b1;
        else if (rd_stb || grst_stb)     st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign power_o = st_q.power;
    assign pend_o  = st_q.pend;

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pwr || ev_store || ev_play) |=> pend_o);
    assert_pwr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwr |=> (flags_o.pwr_rdy && power_o == $past(pwr_val)));
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !ev_pwr && !ev_store && !ev_play) |=> (!pend_o && !flags_o.pwr_rdy));
    assert_store_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_load && !grst_stb && flags_o.store_done) |=> flags_o.store_done);
    assert_play_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (play_load && !ev_play) |=> !flags_o.play_done);
    assert_grst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grst_stb && !ev_pwr && !ev_store && !ev_play) |=> (flags_o == '0 && power_o == '0));
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ev_pwr) |=> (flags_o.pwr_rdy && pend_o));
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
    import stat_pkg::*;
#(
    parameter int unsigned    CW      = CMD_W,
    parameter int unsigned    PW      = PWR_W,
    parameter logic [CW-1:0]  RD_CODE = CODE_STATUS_RD,
    parameter logic [CW-1:0]  GR_CODE = CODE_GEN_RESET,
    localparam int unsigned   SW      = PW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_pwr,
    input  logic          ev_store,
    input  logic          ev_play,
    input  logic [PW-1:0] pwr_val,
    input  logic          irq_en,
    input  logic          store_load,
    input  logic          play_load,
    input  logic          cmd_wr,
    input  logic [CW-1:0] cmd_code,
    output logic [SW-1:0] status_o,
    output logic [SW-1:0] rd_data_o,
    output logic          irq_o
);
    logic          rd_stb, grst_stb, pend;
    flags_t        flags;
    logic [PW-1:0] power;
    logic [SW-1:0] snap_d, snap_q;

    stat_cmd_dec #(.W(CW), .RD_CODE(RD_CODE), .GR_CODE(GR_CODE)) u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_code (cmd_code),
        .rd_stb   (rd_stb),
        .grst_stb (grst_stb)
    );

    stat_flag_bank #(.PW(PW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_pwr     (ev_pwr),
        .ev_store   (ev_store),
        .ev_play    (ev_play),
        .pwr_val    (pwr_val),
        .rd_stb     (rd_stb),
        .grst_stb   (grst_stb),
        .store_load (store_load),
        .play_load  (play_load),
        .flags_o    (flags),
        .power_o    (power),
        .pend_o     (pend)
    );

    always_comb begin
        status_o = {flags.pwr_rdy, flags.store_done, flags.play_done, power};
        irq_o    = pend && irq_en;
        snap_d   = rd_stb ? status_o : snap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign rd_data_o = snap_q;

    assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data_o == $past(status_o)));
    assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_store && irq_en) |=> (irq_o || !irq_en));
    assert_mask_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !cmd_wr && !store_load && !play_load && !ev_pwr && !ev_store && !ev_play)
        |=> $stable(status_o));
    assert_other_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb) |=> $stable(rd_data_o));
endmodule

// File: tb/stat_irq_unit_tb.sv
module stat_irq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_pwr = 0, ev_store = 0, ev_play = 0;
    logic [4:0] pwr_val = '0;
    logic       irq_en = 0, store_load = 0, play_load = 0, cmd_wr = 0;
    logic [7:0] cmd_code = '0;
    logic [7:0] status_o, rd_data_o;
    logic       irq_o;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    stat_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ev_pwr(ev_pwr), .ev_store(ev_store), .ev_play(ev_play),
        .pwr_val(pwr_val), .irq_en(irq_en), .store_load(store_load), .play_load(play_load),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .status_o(status_o), .rd_data_o(rd_data_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_cyc();
        @(negedge clk);
        {ev_pwr, ev_store, ev_play, store_load, play_load, cmd_wr} = '0;
    endtask

    task automatic send_cmd(input logic [7:0] code);
        cmd_wr = 1; cmd_code = code;
        idle_cyc();
    endtask

    task automatic do_reset();
        rst_n = 0; irq_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 8'h00);
        chk("R1 rd_data", rd_data_o, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_events();
        irq_en = 1;
        ev_pwr = 1; pwr_val = 5'h13;
        idle_cyc();
        chk("R2 pwr layout", status_o, 8'h93);
        chk("R3 irq raised", {7'd0, irq_o}, 8'h01);
        ev_store = 1; idle_cyc();
        chk("R2 store bit6", status_o, 8'hD3);
        ev_play = 1; idle_cyc();
        chk("R2 play bit5", status_o, 8'hF3);
    endtask

    task automatic t_mask();
        irq_en = 0; @(negedge clk);
        chk("R4 masked irq", {7'd0, irq_o}, 8'h00);
        chk("R4 flags kept", status_o, 8'hF3);
        irq_en = 1; @(negedge clk);
        chk("R4 unmask irq", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic t_read();
        send_cmd(8'h61);
        chk("R5 snapshot", rd_data_o, 8'hF3);
        chk("R5 pwr cleared", status_o, 8'h73);
        chk("R5 irq cleared", {7'd0, irq_o}, 8'h00);
        chk("R6 store kept on read", {7'd0, status_o[6]}, 8'h01);
        chk("R7 play kept on read", {7'd0, status_o[5]}, 8'h01);
    endtask

    task automatic t_other_code();
        send_cmd(8'h62);
        send_cmd(8'h00);
        chk("R10 status", status_o, 8'h73);
        chk("R10 rd_data", rd_data_o, 8'hF3);
        chk("R10 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_loads();
        store_load = 1; idle_cyc();
        chk("R6 store cleared", status_o, 8'h33);
        play_load = 1; idle_cyc();
        chk("R7 play cleared", status_o, 8'h13);
    endtask

    task automatic t_collide();
        ev_pwr = 1; pwr_val = 5'h07; idle_cyc();
        cmd_wr = 1; cmd_code = 8'h61; ev_pwr = 1; pwr_val = 5'h1F;
        idle_cyc();
        chk("R9 reply lacks new event", rd_data_o, 8'h87);
        chk("R9 flag kept", status_o, 8'h9F);
        chk("R9 irq rearmed", {7'd0, irq_o}, 8'h01);
        ev_store = 1; store_load = 1; idle_cyc();
        chk("R9 store wins load", {7'd0, status_o[6]}, 8'h01);
    endtask

    task automatic t_grst();
        ev_play = 1; idle_cyc();
        send_cmd(8'h01);
        chk("R8 all cleared", status_o, 8'h00);
        chk("R8 irq cleared", {7'd0, irq_o}, 8'h00);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_events();
        t_mask();
        t_read();
        t_other_code();
        t_loads();
        t_collide();
        t_grst();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule